// File: doc/BRIEF.md
# SPI Master Register Front End with Enable Gating

This block is the software-visible register layer of an SPI master. It decodes a simple word-addressed read/write bus into a small register set: receive data, transmit data, control, interrupt enable, status and message data. Its outputs are push and pop strobes toward external TX and RX FIFOs, a flush strobe for both FIFOs, active-low chip selects and an interrupt line. The serial shifter and the FIFO storage sit outside the block. This block only produces the side effects of register accesses.

The control register carries an enable bit, and every other register is gated on it. While the block is disabled it discards writes to everything except control. Reads return only the stored reset values, and neither the FIFOs nor the interrupt change. A control write that leaves the enable bit clear acts as a soft reset. It restores every register except control, flushes both FIFOs, re-evaluates the interrupt and releases every chip select.

Top module: `spireg_top`

## Requirements
- R1: The register index is the byte address shifted right by two, so address bits [1:0] are ignored. Index 0 is RX data, 1 is TX data, 2 is control, 3 is interrupt enable, 4 is status and 5 is message data. A read of an index of 6 or above returns zero, and a write there changes nothing.
- R2: While control bit 0 (enable) is clear, writes to every register except control are discarded. They cause no TX push and leave status and interrupt enable unchanged.
- R3: While enable is clear, a read returns the stored value of the register: control as written, status 0x00000003, and zero for every other register. It never pops the RX FIFO and never changes the interrupt output.
- R4: A control write with bit 0 clear raises fifoFlush in the same cycle. From the next cycle, status is 0x00000003, interrupt enable is zero, the interrupt is low and all chip selects are high, while control holds the written value.
- R5: After hardware reset, control reads zero and status reads 0x00000003. The interrupt output is low and every chip select is high.
- R6: When enable (bit 0) and master mode (bit 1) are both set, the chip select whose number equals control bits [5:4] is low and the others are high. In every other case all chip selects are high.
- R7: While enabled, a TX data write pulses txPush in the same cycle with txPushData equal to the write data, unless txFull is high, in which case nothing is pushed. Reads of TX data and message data return zero.
- R8: While enabled, an RX data read returns rxData and pulses rxPop in the same cycle when rxEmpty is low. When rxEmpty is high it returns the filler word 0xBAD0F00D and does not pop.
- R9: The interrupt output is registered. After each enabled in-range access it equals the OR over all bits of (status AND interrupt enable), and it changes at no other time except at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRe |
| txPush | output | 1 | Push strobe toward the TX FIFO |
| txPushData | output | 32 | Word pushed to the TX FIFO |
| txFull | input | 1 | TX FIFO full |
| rxPop | output | 1 | Pop strobe toward the RX FIFO |
| rxData | input | 32 | Head word of the RX FIFO |
| rxEmpty | input | 1 | RX FIFO empty |
| fifoFlush | output | 1 | Empty both FIFOs (soft reset) |
| csN | output | 4 | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
Read data, txPush, rxPop and fifoFlush are combinational from the bus inputs and the stored state. The bench checks them one nanosecond after it drives an access, before the clock edge that commits that access. The interrupt, the chip selects and the register contents change at that edge. The bench checks them one nanosecond after the edge, and checks register contents through a later read. Expected values come from a bench-side model that is updated exactly at the committing edge.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int REG_RX   = 0;
  localparam int REG_TX   = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_IEN  = 3;
  localparam int REG_STAT = 4;
  localparam int REG_MSG  = 5;
  localparam int NUM_REGS = 6;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_MASTER   = 1;
  localparam int CTRL_CHAN_LSB = 4;

  localparam logic [31:0] STAT_RESET = 32'h0000_0003;
  localparam logic [31:0] RX_FILLER  = 32'hBAD0_F00D;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CTRL, RD_IEN, RD_STAT, RD_RX, RD_FILL
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrIen;
    logic   wrStat;
    logic   softRst;
    logic   pushTx;
    logic   popRx;
    logic   evalIrq;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEnBit,
  input  logic              enQ,
  input  logic              txFull,
  input  logic              rxEmpty,
  output strobe_t           stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic inRange;
  logic access;

  assign idx     = busAddr[ADDR_W-1:2];
  assign inRange = int'(idx) < NUM_REGS;
  assign access  = busWe || busRe;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_ZERO;
    stb.wrCtrl  = busWe && inRange && (int'(idx) == REG_CTRL);
    stb.softRst = stb.wrCtrl && !wrEnBit;
    stb.wrIen   = busWe && enQ && (int'(idx) == REG_IEN);
    stb.wrStat  = busWe && enQ && (int'(idx) == REG_STAT);
    stb.pushTx  = busWe && enQ && (int'(idx) == REG_TX) && !txFull;
    stb.popRx   = busRe && enQ && (int'(idx) == REG_RX) && !rxEmpty;
    stb.evalIrq = inRange && access && (enQ || stb.wrCtrl);
    if (busRe && inRange) begin
      case (int'(idx))
        REG_CTRL: stb.rdSel = RD_CTRL;
        REG_IEN:  stb.rdSel = RD_IEN;
        REG_STAT: stb.rdSel = RD_STAT;
        REG_RX:   if (enQ) stb.rdSel = rxEmpty ? RD_FILL : RD_RX;
        default:  stb.rdSel = RD_ZERO;
      endcase
    end
  end

  // R2 / R3: no FIFO side effect while disabled
  assert_no_fifo_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> (!stb.pushTx && !stb.popRx));

  // R1: out-of-range access touches nothing
  assert_out_of_range_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (access && !inRange) |-> (stb.rdSel == RD_ZERO && !stb.wrCtrl && !stb.evalIrq));
endmodule

// File: rtl/spireg_datapath.sv
module spireg_datapath
  import spireg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [31:0] busWdata,
  input  logic [31:0] rxData,
  output logic [31:0] busRdata,
  output logic [31:0] ctrlQ,
  output logic        irq
);
  logic [31:0] ienQ, statQ;
  logic [31:0] ienD, statD, ctrlD;
  logic        irqQ;

  always_comb begin
    ctrlD = stb.wrCtrl ? busWdata : ctrlQ;
    ienD  = ienQ;
    statD = statQ;
    if (stb.softRst) begin
      ienD  = '0;
      statD = STAT_RESET;
    end else begin
      if (stb.wrIen)  ienD  = busWdata;
      if (stb.wrStat) statD = busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      ienQ  <= '0;
      statQ <= STAT_RESET;
      irqQ  <= 1'b0;
    end else begin
      ctrlQ <= ctrlD;
      ienQ  <= ienD;
      statQ <= statD;
      if (stb.evalIrq) irqQ <= |(statD & ienD);
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_CTRL: busRdata = ctrlQ;
      RD_IEN:  busRdata = ienQ;
      RD_STAT: busRdata = statQ;
      RD_RX:   busRdata = rxData;
      RD_FILL: busRdata = RX_FILLER;
      default: busRdata = '0;
    endcase
  end

  assign irq = irqQ;

  // R4: soft reset restores registers and drops the interrupt
  assert_soft_reset_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (statQ == STAT_RESET && ienQ == '0 && !irqQ));

  // R2: disabled block keeps its registers
  assert_disabled_regs_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[CTRL_EN] && !stb.wrCtrl) |=> ($stable(statQ) && $stable(ienQ)));

  // R3: disabled access leaves the interrupt alone
  assert_disabled_irq_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[CTRL_EN] && !stb.wrCtrl) |=> $stable(irqQ));

  // R9: interrupt tracks enabled status bits
  assert_irq_consistent_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == |(statQ & ienQ));
endmodule

// File: rtl/spireg_csdec.sv
module spireg_csdec #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              active,
  input  logic [CS_W-1:0]   chan,
  output logic [NUM_CS-1:0] csN
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(active && (int'(chan) == i));
  end

  // R6: at most one select asserted, none when idle
  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  assert_cs_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (&csN));
endmodule

// File: rtl/spireg_top.sv
module spireg_top
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txPush,
  output logic [31:0]       txPushData,
  input  logic              txFull,
  output logic              rxPop,
  input  logic [31:0]       rxData,
  input  logic              rxEmpty,
  output logic              fifoFlush,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  strobe_t     stb;
  logic [31:0] ctrlQ;
  logic        enQ;

  assign enQ = ctrlQ[CTRL_EN];

  spireg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .wrEnBit(busWdata[CTRL_EN]), .enQ(enQ), .txFull(txFull), .rxEmpty(rxEmpty),
    .stb(stb)
  );

  spireg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .rxData(rxData),
    .busRdata(busRdata), .ctrlQ(ctrlQ), .irq(irq)
  );

  spireg_csdec #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .clk(clk), .rstN(rstN),
    .active(ctrlQ[CTRL_EN] && ctrlQ[CTRL_MASTER]),
    .chan(ctrlQ[CTRL_CHAN_LSB +: CS_W]),
    .csN(csN)
  );

  assign txPush     = stb.pushTx;
  assign txPushData = busWdata;
  assign rxPop      = stb.popRx;
  assign fifoFlush  = stb.softRst;
endmodule

// File: tb/spireg_top_test.sv
module spireg_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, txPushData, rxData = '0;
  logic        txPush, txFull = 1'b0, rxPop, rxEmpty = 1'b1, fifoFlush, irq;
  logic [3:0]  csN;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mCtrl, mStat, mIen;
  logic        mIrq;

  always #4 clk = ~clk;

  spireg_top uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txPush(txPush), .txPushData(txPushData),
    .txFull(txFull), .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty),
    .fifoFlush(fifoFlush), .csN(csN), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expCs(input logic [31:0] c);
    logic [3:0] r = 4'hF;
    if (c[0] && c[1]) r[c[5:4]] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] expRd(input int idx, input logic [31:0] rd, input logic emp);
    if (idx >= 6) return 32'h0;
    case (idx)
      2: return mCtrl;
      3: return mIen;
      4: return mStat;
      0: return (mCtrl[0] ? (emp ? 32'hBAD0_F00D : rd) : 32'h0);
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = '0; mStat = 32'h3; mIen = '0; mIrq = 1'b0;
  endtask

  task automatic access(input bit we, input bit re, input logic [7:0] addr, input logic [31:0] wd,
                        input bit full, input bit emp, input logic [31:0] rd);
    int idx = int'(addr[7:2]);
    bit en = mCtrl[0];
    @(negedge clk);
    busWe = we; busRe = re; busAddr = addr; busWdata = wd;
    txFull = full; rxEmpty = emp; rxData = rd;
    #1;
    if (re) check(busRdata === expRd(idx, rd, emp),
                  (idx >= 6) ? "R1 out-of-range read" : (en ? "R8/R7 read data" : "R3 disabled read"),
                  busRdata, expRd(idx, rd, emp));
    check(txPush === (we && idx == 1 && en && !full), "R7 txPush", 32'(txPush), 32'(we && idx == 1 && en && !full));
    if (txPush) check(txPushData === wd, "R7 txPushData", txPushData, wd);
    check(rxPop === (re && idx == 0 && en && !emp), "R8/R3 rxPop", 32'(rxPop), 32'(re && idx == 0 && en && !emp));
    check(fifoFlush === (we && idx == 2 && !wd[0]), "R4 fifoFlush", 32'(fifoFlush), 32'(we && idx == 2 && !wd[0]));
    @(posedge clk);
    #1;
    busWe = 0; busRe = 0;
    if (idx < 6 && (we || re)) begin
      if (we && idx == 2) begin
        mCtrl = wd;
        if (!wd[0]) begin mStat = 32'h3; mIen = '0; end
      end else if (we && en && idx == 3) mIen = wd;
      else if (we && en && idx == 4) mStat = wd;
      if (en || (we && idx == 2)) mIrq = |(mStat & mIen);
    end
    check(csN === expCs(mCtrl), "R6 chip selects", 32'(csN), 32'(expCs(mCtrl)));
    check(irq === mIrq, "R9 irq", 32'(irq), 32'(mIrq));
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishTest();
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    #20 rstN = 1'b1;
    @(negedge clk);
    check(csN === 4'hF && irq === 1'b0, "R5 reset outputs", {27'h0, irq, csN}, 32'hF);
    // R5 reset values readable
    access(0, 1, 8'h08, 0, 0, 1, 0);
    access(0, 1, 8'h10, 0, 0, 1, 0);
    // R2: writes while disabled discarded
    access(1, 0, 8'h0C, 32'hFFFF_FFFF, 0, 1, 0);
    access(1, 0, 8'h04, 32'h1234_5678, 0, 1, 0);
    access(1, 0, 8'h10, 32'h0, 0, 1, 0);
    // R3: disabled RX read with data present -> zero, no pop
    access(0, 1, 8'h00, 0, 0, 0, 32'hCAFE_0001);
    // enable master on channel 2 (R6)
    access(1, 0, 8'h08, 32'h0000_0023, 0, 1, 0);
    access(0, 1, 8'h0C, 0, 0, 1, 0); // R2: ien still zero
    // R9 and R1 aliasing: offset 0x0F maps to interrupt enable
    access(1, 0, 8'h0F, 32'h0000_0002, 0, 1, 0);
    access(0, 1, 8'h12, 0, 0, 1, 0);
    // R1 out-of-range write changes nothing
    access(1, 0, 8'h18, 32'hFFFF_FFFF, 0, 1, 0);
    access(0, 1, 8'h1C, 0, 0, 1, 0);
    // R7 full and not full, R8 empty and not
    access(1, 0, 8'h04, 32'hA5A5_0001, 1, 1, 0);
    access(1, 0, 8'h04, 32'hA5A5_0002, 0, 1, 0);
    access(0, 1, 8'h04, 0, 0, 1, 0);
    access(0, 1, 8'h14, 0, 0, 1, 0);
    access(0, 1, 8'h00, 0, 0, 1, 32'h1111_2222);
    access(0, 1, 8'h00, 0, 0, 0, 32'h3333_4444);
    // R4 soft reset while irq high
    access(1, 0, 8'h08, 32'h0000_0032, 0, 1, 0);
    access(0, 1, 8'h08, 0, 0, 1, 0);
    access(0, 1, 8'h10, 0, 0, 1, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int kind = $urandom_range(0, 9);
      logic [7:0] a = 8'($urandom_range(0, 31));
      logic [31:0] w = $urandom;
      if (a[7:2] == 6'd2) w[0] = ($urandom_range(0, 3) != 0);
      access(kind < 5, kind >= 5, a, w, $urandom_range(0, 1), $urandom_range(0, 1), $urandom);
    end
    // R5 hardware reset mid-run
    access(1, 0, 8'h08, 32'h0000_0013, 0, 1, 0);
    access(1, 0, 8'h10, 32'h0000_00F0, 0, 1, 0);
    access(1, 0, 8'h0C, 32'h0000_0010, 0, 1, 0);
    @(negedge clk); rstN = 1'b0;
    #3;
    check(csN === 4'hF && irq === 1'b0, "R5 hw reset outputs", {27'h0, irq, csN}, 32'hF);
    modelReset();
    @(negedge clk); rstN = 1'b1;
    access(0, 1, 8'h08, 0, 0, 1, 0);
    access(0, 1, 8'h10, 0, 0, 1, 0);
    finishTest();
  end
endmodule